// File: doc/BRIEF.md
# Cause/Mask Interrupt Aggregator

This block merges 32 level-sensitive interrupt request lines into one registered interrupt line. That line is meant to drive a cascade input on a parent controller. Each source n has bit n in a cause register and bit n in a mask register. Software uses a small 32-bit register port to enable sources, to acknowledge requests and to find the next source to service.

A request that is high on a clock edge sets its cause bit. Software clears cause bits by writing ones to them. The output is asserted while any source is both pending and enabled. A read-only register reports the lowest-numbered source that is pending and enabled, so the service routine can pick that source with a single read.

Top module: `irq_agg`

## Requirements
- R1: After reset, the cause register, the mask register, `irqOut` and `rdData` are all zero.
- R2: The register map is: cause at byte address 0x0, mask at 0x4, next-source register at 0x8. `rdData` is registered. After a clock edge it holds the addressed register as it stood before that edge.
- R3: A write to 0x0 clears every cause bit whose data bit is 1. Cause bits whose data bit is 0 keep their value.
- R4: A cause bit is set on any edge where its source input is high. When a clearing write and an active source meet on the same bit, the bit stays set.
- R5: A write to 0x4 loads all 32 mask bits, and a read of 0x4 returns them. A 1 in a mask bit enables that source.
- R6: `irqOut` is a register. After each edge it equals the OR over all bits of (cause AND mask) as they stood before that edge, so it follows a new pending bit one cycle later.
- R7: A read of 0x8 returns the index of the lowest set bit of (cause AND mask) in bits 4:0, and 1 in bit 31 when that AND is nonzero. Every other bit reads 0, and the whole word is 0 when nothing is pending. Writes to 0x8 change no register.
- R8: Any address other than 0x0, 0x4 or 0x8 reads as zero, and writes to it change no register.
- R9: Writing 0 to the mask register and then all ones to the cause register leaves `irqOut` low and the cause register zero. The only exception is a cause bit whose source is still high, which stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Byte address of the register access |
| wrEn | input | 1 | Write strobe for the current cycle |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| srcIn | input | 32 | Level-sensitive interrupt requests, bit n is source n |
| irqOut | output | 1 | Combined interrupt output |

## Verification
The assertions assume that at most one register access is made per cycle, and that the address decode never selects the cause and the mask register together. They also assume that no source can be hidden by a clear: any source that is high on an edge must show in the cause register after that edge. The bench meets these assumptions by driving every input on the falling edge and by holding each source for whole cycles. It makes one access per task call and keeps all sources low when it checks that a clear takes effect.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int IDX_W  = $clog2(DATA_W);

  localparam logic [ADDR_W-1:0] OFS_CAUSE = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_NEXT  = 4'h8;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_CAUSE = 2'd1,
    RD_MASK  = 2'd2,
    RD_NEXT  = 2'd3
  } rdSel_t;

  typedef struct packed {
    logic   causeWr;
    logic   maskWr;
    rdSel_t rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes = '{causeWr: 1'b0, maskWr: 1'b0, rdSel: RD_NONE};
    unique case (addr)
      OFS_CAUSE: begin
        strobes.causeWr = wrEn;
        strobes.rdSel   = RD_CAUSE;
      end
      OFS_MASK: begin
        strobes.maskWr = wrEn;
        strobes.rdSel  = RD_MASK;
      end
      OFS_NEXT: strobes.rdSel = RD_NEXT;
      default:  strobes.rdSel = RD_NONE;
    endcase
  end

  // R2: at most one register is written per access
  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.causeWr, strobes.maskWr}));

  // R8: unmapped addresses never produce a write strobe
  assert_unmapped_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (addr != OFS_CAUSE && addr != OFS_MASK) |-> !(strobes.causeWr || strobes.maskWr));
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] srcIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [DATA_W-1:0] causeQ;
  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] activeVec;
  logic [DATA_W-1:0] clearVec;
  logic [IDX_W-1:0]  nextIdx;
  logic              nextValid;
  logic [DATA_W-1:0] nextWord;
  logic [DATA_W-1:0] rdMux;

  assign clearVec  = strobes.causeWr ? wrData : '0;
  assign activeVec = causeQ & maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ <= '0;
      maskQ  <= '0;
      irqOut <= 1'b0;
      rdData <= '0;
    end else begin
      causeQ <= (causeQ & ~clearVec) | srcIn;
      if (strobes.maskWr) maskQ <= wrData;
      irqOut <= |activeVec;
      rdData <= rdMux;
    end
  end

  // lowest set bit of activeVec
  always_comb begin
    nextIdx   = '0;
    nextValid = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (activeVec[i]) begin
        nextIdx   = IDX_W'(i);
        nextValid = 1'b1;
      end
    end
  end

  always_comb begin
    nextWord             = '0;
    nextWord[IDX_W-1:0]  = nextIdx;
    nextWord[DATA_W-1]   = nextValid;
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_CAUSE: rdMux = causeQ;
      RD_MASK:  rdMux = maskQ;
      RD_NEXT:  rdMux = nextWord;
      default:  rdMux = '0;
    endcase
  end

  // R4: an active source is visible in cause after the edge
  assert_src_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    (srcIn != '0) |=> ((causeQ & $past(srcIn)) == $past(srcIn)));

  // R3: a clearing write with quiet sources leaves the written bits at zero
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.causeWr && srcIn == '0) |=> ((causeQ & $past(wrData)) == '0));

  // R5: mask holds its value without a mask write
  assert_mask_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.maskWr |=> $stable(maskQ));

  // R6: output follows pending state one cycle later
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    (activeVec != '0) |=> irqOut);
  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    (activeVec == '0) |=> !irqOut);

  // R7: reported index is pending and no lower source is pending
  assert_next_lowest_R7: assert property (@(posedge clk) disable iff (!rstN)
    nextValid |-> (activeVec[nextIdx] &&
                   ((activeVec & ((DATA_W'(1) << nextIdx) - DATA_W'(1))) == '0)));
  assert_next_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    nextValid == (activeVec != '0));
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] srcIn,
  output logic              irqOut
);
  ctrlStrobes_t strobes;

  irq_agg_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrEn    (wrEn),
    .strobes (strobes)
  );

  irq_agg_datapath uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .srcIn   (srcIn),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/irq_agg_test.sv
module irq_agg_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] srcIn = '0;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_agg uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .srcIn(srcIn), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] mask;
    logic [31:0] next;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{src: 32'h0000_0001, mask: 32'hFFFF_FFFF, next: 32'h8000_0000},
    '{src: 32'h8000_0000, mask: 32'hFFFF_FFFF, next: 32'h8000_001F},
    '{src: 32'h0000_00F0, mask: 32'h0000_0060, next: 32'h8000_0005},
    '{src: 32'h0001_0000, mask: 32'h0000_FFFF, next: 32'h0000_0000},
    '{src: 32'hA000_0000, mask: 32'hFFFF_0000, next: 32'h8000_001D},
    '{src: 32'h0000_0000, mask: 32'hFFFF_FFFF, next: 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wrEn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = rdData;
  endtask

  task automatic pulseSrc(input logic [31:0] s);
    @(negedge clk);
    srcIn = s;
    @(posedge clk);
    @(negedge clk);
    srcIn = '0;
  endtask

  task automatic quiesce();
    writeReg(4'h4, 32'h0);
    writeReg(4'h0, 32'hFFFF_FFFF);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 irqOut at reset", {31'b0, irqOut}, 32'h0);
    check("R1 rdData at reset", rdData, 32'h0);
    rstN = 1'b1;
    readReg(4'h0, v); check("R1 cause at reset", v, 32'h0);
    readReg(4'h4, v); check("R1 mask at reset", v, 32'h0);
    readReg(4'h8, v); check("R1 next at reset", v, 32'h0);

    // table walk: R2 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      pulseSrc(VECS[i].src);
      writeReg(4'h4, VECS[i].mask);
      readReg(4'h0, v); check($sformatf("R2 cause vec %0d", i), v, VECS[i].src);
      readReg(4'h4, v); check($sformatf("R5 mask vec %0d", i), v, VECS[i].mask);
      readReg(4'h8, v); check($sformatf("R7 next vec %0d", i), v, VECS[i].next);
      check($sformatf("R6 irqOut vec %0d", i), {31'b0, irqOut}, {31'b0, VECS[i].next[31]});
      quiesce();
    end

    // R3: partial write-one-to-clear
    pulseSrc(32'h0000_0003);
    writeReg(4'h0, 32'h0000_0001);
    readReg(4'h0, v); check("R3 partial clear", v, 32'h0000_0002);
    writeReg(4'h0, 32'h0000_0000);
    readReg(4'h0, v); check("R3 zero write no effect", v, 32'h0000_0002);
    quiesce();

    // R4: set wins over clear on the same bit
    @(negedge clk); srcIn = 32'h0000_0008;
    writeReg(4'h0, 32'h0000_0008);
    readReg(4'h0, v); check("R4 set wins", v, 32'h0000_0008);
    @(negedge clk); srcIn = '0;
    writeReg(4'h0, 32'h0000_0008);
    readReg(4'h0, v); check("R4 clear after source drop", v, 32'h0);

    // R6: output one cycle behind cause
    writeReg(4'h4, 32'hFFFF_FFFF);
    @(negedge clk); srcIn = 32'h0000_0100;
    @(posedge clk);
    @(negedge clk); srcIn = '0;
    check("R6 irqOut not yet", {31'b0, irqOut}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R6 irqOut one cycle later", {31'b0, irqOut}, 32'h1);

    // R7: writes to next register ignored
    writeReg(4'h8, 32'h0000_0000);
    readReg(4'h0, v); check("R7 write to next ignored (cause)", v, 32'h0000_0100);
    readReg(4'h4, v); check("R7 write to next ignored (mask)", v, 32'hFFFF_FFFF);

    // R8: unmapped address
    writeReg(4'hC, 32'h0000_0000);
    readReg(4'hC, v); check("R8 unmapped reads zero", v, 32'h0);
    readReg(4'h4, v); check("R8 mask untouched", v, 32'hFFFF_FFFF);
    writeReg(4'h1, 32'hFFFF_FFFF);
    readReg(4'h0, v); check("R8 cause untouched", v, 32'h0000_0100);

    // R9: quiesce, with one source still high
    @(negedge clk); srcIn = 32'h0000_0004;
    quiesce();
    readReg(4'h0, v); check("R9 held source stays", v, 32'h0000_0104 & 32'h0000_0004);
    check("R9 irqOut low", {31'b0, irqOut}, 32'h0);
    @(negedge clk); srcIn = '0;
    quiesce();
    readReg(4'h0, v); check("R9 fully quiet", v, 32'h0);
    readReg(4'h8, v); check("R9 next empty", v, 32'h0);
    check("R9 irqOut low after quiet", {31'b0, irqOut}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule